// File: doc/BRIEF.md
# Bus and Software Reset Combiner

This block sits between the host bus and the local side of a bridge. It merges two reset sources and turns them into the signals the rest of the bridge uses. The first source is the active-low bus reset input. The second is a software reset bit that the host writes. The outputs are a local reset, an indicator output, a clear strobe for the configuration registers, output-enable and force-low controls for the local pin groups, a read-ahead invalidate pulse, and the accept/refuse answer for each host access.

Bus reset is the heavy reset. It asserts asynchronously and releases through a synchroniser chain. While it is active, the configuration registers are held at their defaults. The general local outputs float, and the local data and GPIO pins are driven low. No host access gets an answer.

Software reset is the light reset. It holds only the local side in reset. It leaves the configuration registers and the host interface untouched. While it is set, configuration accesses are accepted and local accesses are refused. It lasts until the host writes the bit back to 0.

Top module: `bus_sw_reset_ctrl`

## Requirements
- R1: `local_rst_n` goes low at once, without waiting for a clock, when `bus_rst_n` is low. It also goes low two rising edges after the edge that samples `host_we`=1 with `host_wdata`=1.
- R2: After `bus_rst_n` rises, `local_rst_n`, `led_n` and `regs_clear` keep their reset values for SYNC_STAGES rising edges. They release on edge SYNC_STAGES+1.
- R3: `led_n` is low and `regs_clear` is high exactly while bus reset is in effect. Software reset leaves `regs_clear` at 0 and `led_n` at 1.
- R4: Once written to 1, the software reset bit stays set until the host writes 0. Repeated writes of 1 and idle cycles do not release it. After a write of 0, `local_rst_n` returns to 1 two edges after the write edge.
- R5: Each request (`acc_req`=1) gets its answer one edge later. Outside any reset, every request gets `acc_ack`=1. During software reset, a configuration request (`acc_cfg`=1) gets `acc_ack`=1, and a local request (`acc_cfg`=0) gets `acc_retry`=1. `acc_ack` and `acc_retry` are never both 1.
- R6: While bus reset is in effect, requests get neither `acc_ack` nor `acc_retry`.
- R7: During bus reset, `ctl_oe` is all zeros, and `data_low` and `gpio_low` are all ones. Otherwise, including during software reset, `ctl_oe` is all ones and `data_low` and `gpio_low` are all zeros.
- R8: `rdahead_flush` is high for exactly one cycle, in the same cycle in which `local_rst_n` first falls because of software reset. Writing 1 while the bit is already set gives no pulse.
- R9: Bus reset clears the software reset bit. After release, `local_rst_n` returns to 1 even though no write of 0 was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| bus_rst_n | input | 1 | Bus reset, active low, asynchronous |
| host_we | input | 1 | Host write strobe for the software reset bit |
| host_wdata | input | 1 | Value written to the software reset bit |
| acc_req | input | 1 | Host access request present this cycle |
| acc_cfg | input | 1 | 1 = configuration access, 0 = local access |
| acc_ack | output | 1 | Access accepted |
| acc_retry | output | 1 | Access refused, host must retry |
| local_rst_n | output | 1 | Local reset, active low |
| led_n | output | 1 | Bus-reset indicator, active low |
| regs_clear | output | 1 | Hold configuration registers at defaults |
| ctl_oe | output | N_CTL | Drive enables for general local outputs |
| data_low | output | DATA_W | Force-low controls for local data pins |
| gpio_low | output | GPIO_W | Force-low controls for multiplexed GPIO pins |
| rdahead_flush | output | 1 | One-cycle read-ahead invalidate pulse |

## Verification
The bench builds the block with SYNC_STAGES=3, N_CTL=4, DATA_W=8 and GPIO_W=2. The three-stage chain makes the release latency differ from the default. This shows the SYNC_STAGES+1 edge count in R2 is derived from the parameter and not fixed at two. The narrow pin groups let whole vectors be compared directly for the all-ones and all-zeros patterns. Bus reset is also asserted mid-cycle while software reset is set, which exercises the asynchronous assertion and the clearing of the bit together.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_ACK   = 2'd1,
    RSP_RETRY = 2'd2
  } rsp_e;

  localparam int MIN_SYNC = 2;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic hold
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= (chain << 1) | STAGES'(1);
  end

  assign hold = ~chain[STAGES-1];
endmodule

// File: rtl/rstc_swbit.sv
module rstc_swbit (
  input  logic clk,
  input  logic arst_n,
  input  logic hold,
  input  logic we,
  input  logic wdata,
  output logic sw_q,
  output logic flush
);
  logic prev_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sw_q   <= 1'b0;
      prev_q <= 1'b0;
      flush  <= 1'b0;
    end else if (hold) begin
      sw_q   <= 1'b0;
      prev_q <= 1'b0;
      flush  <= 1'b0;
    end else begin
      if (we) sw_q <= wdata;
      prev_q <= sw_q;
      flush  <= sw_q & ~prev_q;
    end
  end
endmodule

// File: rtl/rstc_pins.sv
module rstc_pins #(
  parameter int N_CTL  = 16,
  parameter int DATA_W = 32,
  parameter int GPIO_W = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              hold,
  output logic [N_CTL-1:0]  ctl_oe,
  output logic [DATA_W-1:0] data_low,
  output logic [GPIO_W-1:0] gpio_low
);
  logic in_rst_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) in_rst_q <= 1'b1;
    else         in_rst_q <= hold;
  end

  for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
    assign ctl_oe[i] = ~in_rst_q;
  end
  for (genvar j = 0; j < DATA_W; j++) begin : g_data
    assign data_low[j] = in_rst_q;
  end
  for (genvar k = 0; k < GPIO_W; k++) begin : g_gpio
    assign gpio_low[k] = in_rst_q;
  end
endmodule

// File: rtl/rstc_acc.sv
module rstc_acc
  import rstc_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic hold,
  input  logic sw_q,
  input  logic req,
  input  logic cfg,
  output logic ack,
  output logic retry
);
  rsp_e rsp_q, rsp_d;

  always_comb begin
    rsp_d = RSP_NONE;
    if (!hold && req) begin
      if (sw_q && !cfg) rsp_d = RSP_RETRY;
      else              rsp_d = RSP_ACK;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rsp_q <= RSP_NONE;
    else         rsp_q <= rsp_d;
  end

  assign ack   = (rsp_q == RSP_ACK);
  assign retry = (rsp_q == RSP_RETRY);
endmodule

// File: rtl/bus_sw_reset_ctrl.sv
module bus_sw_reset_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int N_CTL       = 16,
  parameter int DATA_W      = 32,
  parameter int GPIO_W      = 4
) (
  input  logic              clk,
  input  logic              bus_rst_n,
  input  logic              host_we,
  input  logic              host_wdata,
  input  logic              acc_req,
  input  logic              acc_cfg,
  output logic              acc_ack,
  output logic              acc_retry,
  output logic              local_rst_n,
  output logic              led_n,
  output logic              regs_clear,
  output logic [N_CTL-1:0]  ctl_oe,
  output logic [DATA_W-1:0] data_low,
  output logic [GPIO_W-1:0] gpio_low,
  output logic              rdahead_flush
);
  localparam int STAGES = (SYNC_STAGES < rstc_pkg::MIN_SYNC) ? rstc_pkg::MIN_SYNC : SYNC_STAGES;

  logic bus_hold;
  logic sw_q;

  rstc_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .arst_n(bus_rst_n), .hold(bus_hold)
  );

  rstc_swbit u_sw (
    .clk(clk), .arst_n(bus_rst_n), .hold(bus_hold),
    .we(host_we), .wdata(host_wdata), .sw_q(sw_q), .flush(rdahead_flush)
  );

  rstc_pins #(.N_CTL(N_CTL), .DATA_W(DATA_W), .GPIO_W(GPIO_W)) u_pins (
    .clk(clk), .arst_n(bus_rst_n), .hold(bus_hold),
    .ctl_oe(ctl_oe), .data_low(data_low), .gpio_low(gpio_low)
  );

  rstc_acc u_acc (
    .clk(clk), .arst_n(bus_rst_n), .hold(bus_hold), .sw_q(sw_q),
    .req(acc_req), .cfg(acc_cfg), .ack(acc_ack), .retry(acc_retry)
  );

  // Output flops: asserted asynchronously by the bus reset, released in step.
  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      local_rst_n <= 1'b0;
      led_n       <= 1'b0;
      regs_clear  <= 1'b1;
    end else begin
      local_rst_n <= ~(bus_hold | sw_q);
      led_n       <= ~bus_hold;
      regs_clear  <= bus_hold;
    end
  end
endmodule

// File: rtl/bus_sw_reset_ctrl_chk.sv
module bus_sw_reset_ctrl_chk #(
  parameter int N_CTL  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              bus_rst_n,
  input logic              host_we,
  input logic              host_wdata,
  input logic              acc_ack,
  input logic              acc_retry,
  input logic              local_rst_n,
  input logic              led_n,
  input logic              regs_clear,
  input logic [N_CTL-1:0]  ctl_oe,
  input logic [DATA_W-1:0] data_low,
  input logic              rdahead_flush
);
  p_sw_write_resets_r1: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (host_we && host_wdata) |=> ##1 !local_rst_n);

  p_clear_with_led_r3: assert property (@(posedge clk) disable iff (!bus_rst_n)
    regs_clear |-> !led_n);

  p_one_answer_r5: assert property (@(posedge clk) disable iff (!bus_rst_n)
    !(acc_ack && acc_retry));

  p_retry_in_swrst_r5: assert property (@(posedge clk) disable iff (!bus_rst_n)
    acc_retry |-> !local_rst_n);

  p_silent_in_busrst_r6: assert property (@(posedge clk) disable iff (!bus_rst_n)
    regs_clear |-> (!acc_ack && !acc_retry));

  p_pins_in_busrst_r7: assert property (@(posedge clk) disable iff (!bus_rst_n)
    regs_clear |-> (ctl_oe == '0 && data_low == '1));

  p_flush_single_r8: assert property (@(posedge clk) disable iff (!bus_rst_n)
    rdahead_flush |=> !rdahead_flush);

  p_flush_with_rst_r8: assert property (@(posedge clk) disable iff (!bus_rst_n)
    rdahead_flush |-> (!local_rst_n && $fell(local_rst_n)));
endmodule

bind bus_sw_reset_ctrl bus_sw_reset_ctrl_chk #(.N_CTL(N_CTL), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .bus_rst_n(bus_rst_n), .host_we(host_we), .host_wdata(host_wdata),
  .acc_ack(acc_ack), .acc_retry(acc_retry), .local_rst_n(local_rst_n),
  .led_n(led_n), .regs_clear(regs_clear), .ctl_oe(ctl_oe),
  .data_low(data_low), .rdahead_flush(rdahead_flush)
);

// File: tb/sim_bus_sw_reset_ctrl.sv
`timescale 1ns/1ps
module sim_bus_sw_reset_ctrl;
  localparam int S  = 3;
  localparam int NC = 4;
  localparam int DW = 8;
  localparam int GW = 2;

  logic clk = 1'b0;
  logic bus_rst_n = 1'b0;
  logic host_we = 1'b0, host_wdata = 1'b0, acc_req = 1'b0, acc_cfg = 1'b0;
  logic acc_ack, acc_retry, local_rst_n, led_n, regs_clear, rdahead_flush;
  logic [NC-1:0] ctl_oe;
  logic [DW-1:0] data_low;
  logic [GW-1:0] gpio_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_sw_reset_ctrl #(.SYNC_STAGES(S), .N_CTL(NC), .DATA_W(DW), .GPIO_W(GW)) u0 (
    .clk(clk), .bus_rst_n(bus_rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .acc_req(acc_req), .acc_cfg(acc_cfg), .acc_ack(acc_ack), .acc_retry(acc_retry),
    .local_rst_n(local_rst_n), .led_n(led_n), .regs_clear(regs_clear),
    .ctl_oe(ctl_oe), .data_low(data_low), .gpio_low(gpio_low),
    .rdahead_flush(rdahead_flush)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic v);
    host_we = 1'b1; host_wdata = v;
    step();
    host_we = 1'b0; host_wdata = 1'b0;
  endtask

  task automatic chk_pins_idle(input string req);
    chk(req, "ctl_oe", 64'(ctl_oe), 64'({NC{1'b1}}));
    chk(req, "data_low", 64'(data_low), 64'd0);
    chk(req, "gpio_low", 64'(gpio_low), 64'd0);
  endtask

  task automatic chk_pins_rst(input string req);
    chk(req, "ctl_oe", 64'(ctl_oe), 64'd0);
    chk(req, "data_low", 64'(data_low), 64'({DW{1'b1}}));
    chk(req, "gpio_low", 64'(gpio_low), 64'({GW{1'b1}}));
  endtask

  task automatic t_reset_state;
    step(2);
    chk("R1", "local_rst_n in bus reset", 64'(local_rst_n), 64'd0);
    chk("R3", "led_n in bus reset", 64'(led_n), 64'd0);
    chk("R3", "regs_clear in bus reset", 64'(regs_clear), 64'd1);
    chk_pins_rst("R7");
    acc_req = 1'b1; acc_cfg = 1'b1;
    step();
    chk("R6", "ack in bus reset", 64'(acc_ack), 64'd0);
    chk("R6", "retry in bus reset", 64'(acc_retry), 64'd0);
    acc_req = 1'b0;
  endtask

  task automatic t_release;
    bus_rst_n = 1'b1;
    step(S);
    chk("R2", "local_rst_n before release edge", 64'(local_rst_n), 64'd0);
    chk("R2", "regs_clear before release edge", 64'(regs_clear), 64'd1);
    step();
    chk("R2", "local_rst_n released", 64'(local_rst_n), 64'd1);
    chk("R2", "led_n released", 64'(led_n), 64'd1);
    chk("R2", "regs_clear released", 64'(regs_clear), 64'd0);
    chk_pins_idle("R7");
  endtask

  task automatic t_access_normal;
    acc_req = 1'b1; acc_cfg = 1'b0;
    step();
    chk("R5", "local ack normal", 64'(acc_ack), 64'd1);
    chk("R5", "local retry normal", 64'(acc_retry), 64'd0);
    acc_cfg = 1'b1;
    step();
    chk("R5", "cfg ack normal", 64'(acc_ack), 64'd1);
    acc_req = 1'b0;
    step();
    chk("R5", "no request no ack", 64'(acc_ack), 64'd0);
  endtask

  task automatic t_sw_enter;
    host_write(1'b1);
    chk("R1", "local_rst_n one edge after write", 64'(local_rst_n), 64'd1);
    chk("R8", "no flush yet", 64'(rdahead_flush), 64'd0);
    step();
    chk("R1", "local_rst_n two edges after write", 64'(local_rst_n), 64'd0);
    chk("R8", "flush pulse", 64'(rdahead_flush), 64'd1);
    chk("R3", "regs_clear in sw reset", 64'(regs_clear), 64'd0);
    chk("R3", "led_n in sw reset", 64'(led_n), 64'd1);
    chk_pins_idle("R7");
    step();
    chk("R8", "flush single cycle", 64'(rdahead_flush), 64'd0);
    host_write(1'b1);
    step();
    chk("R8", "no flush on rewrite", 64'(rdahead_flush), 64'd0);
    step(5);
    chk("R4", "sw reset holds", 64'(local_rst_n), 64'd0);
  endtask

  task automatic t_access_sw;
    acc_req = 1'b1; acc_cfg = 1'b1;
    step();
    chk("R5", "cfg ack in sw reset", 64'(acc_ack), 64'd1);
    chk("R5", "cfg retry in sw reset", 64'(acc_retry), 64'd0);
    acc_cfg = 1'b0;
    step();
    chk("R5", "local ack in sw reset", 64'(acc_ack), 64'd0);
    chk("R5", "local retry in sw reset", 64'(acc_retry), 64'd1);
    acc_req = 1'b0;
    step();
  endtask

  task automatic t_sw_exit;
    host_write(1'b0);
    chk("R4", "still reset one edge after clear", 64'(local_rst_n), 64'd0);
    step();
    chk("R4", "released two edges after clear", 64'(local_rst_n), 64'd1);
    acc_req = 1'b1; acc_cfg = 1'b0;
    step();
    chk("R5", "local ack after exit", 64'(acc_ack), 64'd1);
    acc_req = 1'b0;
  endtask

  task automatic t_bus_over_sw;
    host_write(1'b1);
    step(2);
    chk("R1", "sw reset before bus reset", 64'(local_rst_n), 64'd0);
    #3 bus_rst_n = 1'b0;
    #1;
    chk("R3", "regs_clear async", 64'(regs_clear), 64'd1);
    chk("R3", "led_n async", 64'(led_n), 64'd0);
    chk_pins_rst("R7");
    step(2);
    bus_rst_n = 1'b1;
    step(S + 1);
    chk("R9", "sw bit cleared by bus reset", 64'(local_rst_n), 64'd1);
    chk("R9", "regs_clear released", 64'(regs_clear), 64'd0);
  endtask

  task automatic t_async_assert;
    step();
    #4 bus_rst_n = 1'b0;
    #1;
    chk("R1", "local_rst_n async assert", 64'(local_rst_n), 64'd0);
    step();
    bus_rst_n = 1'b1;
    step(S + 1);
    chk("R2", "release after async pulse", 64'(local_rst_n), 64'd1);
  endtask

  initial begin
    t_reset_state();
    t_release();
    t_access_normal();
    t_sw_enter();
    t_access_sw();
    t_sw_exit();
    t_bus_over_sw();
    t_async_assert();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule